// File: doc/BRIEF.md
# I/Q Output Conditioning Stage

This block sits between the last filter of a complex transmit path and a pair of D/A converters. Each complex sample (20-bit signed I and Q) passes through a cross-coupled 2x2 balance matrix that corrects gain and phase mismatch of an analog quadrature modulator. Per-channel DC offsets are then added with a resolution of a quarter of an 18-bit output LSB. The result is reduced to a programmable output width with round-half-to-even. It saturates instead of wrapping, and is finally emitted either as two's complement or as offset binary.

Samples enter and leave on valid/ready streams. A sample is taken when `in_valid` and `in_ready` are both high at a rising edge. A result is consumed when `out_valid` and `out_ready` are both high. The four pipeline stages advance together. While a result waits on a low `out_ready`, the whole pipe holds, `in_ready` is low, and the output bus stays unchanged. Bubbles are not squeezed out. Coefficients, offsets, width and format are plain configuration ports and must be held steady while samples are in flight.

Top module: `iq_out_cond`

## Requirements
- R1: Balance: I' = floor((coef_ii·I + coef_iq·Q) / 2^14) and Q' = floor((coef_qq·Q + coef_qi·I) / 2^14). The coefficients are 16-bit signed with unity at 0x4000. I' and Q' are clamped to the 20-bit signed range.
- R2: A 12-bit signed offset per channel is added to the balanced 20-bit value. One offset unit equals one quarter of an output LSB at 18-bit width.
- R3: The output width W comes from cfg_width. Values below 8 act as 8 and values above 18 act as 18. The W-bit result occupies bits 17 down to 18-W of the output bus, and all lower bits are zero.
- R4: Reduction from 20 bits to W bits drops 20-W bits and rounds to nearest. An exact half rounds to the even neighbour, for positive and negative values alike.
- R5: With cfg_offset_bin = 1, output bit 17 is inverted (offset binary). With 0, the result is two's complement.
- R6: A rounded result outside the signed W-bit range is clamped to the nearest end of that range.
- R7: sat_flag rises at the same edge on which a sample that was clamped by R1 or R6 appears on the outputs. It then stays high until reset.
- R8: With out_ready held high, a sample accepted at a rising edge is on the outputs in the fourth cycle after the cycle in which it was presented.
- R9: in_ready equals !out_valid || out_ready. While out_valid is high and out_ready is low, the outputs hold. Every accepted sample comes out exactly once, in order.
- R10: Reset (rst_n low, asynchronous) clears out_valid, sat_flag, out_i and out_q to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can take a sample |
| in_i | input | 20 | In-phase sample, signed |
| in_q | input | 20 | Quadrature sample, signed |
| coef_ii | input | 16 | Direct gain on I, signed, 0x4000 = 1.0 |
| coef_iq | input | 16 | Q-to-I cross term, signed |
| coef_qq | input | 16 | Direct gain on Q, signed |
| coef_qi | input | 16 | I-to-Q cross term, signed |
| ofs_i | input | 12 | I offset in quarter output LSBs, signed |
| ofs_q | input | 12 | Q offset in quarter output LSBs, signed |
| cfg_width | input | 5 | Output width, 8 to 18 |
| cfg_offset_bin | input | 1 | 1 = offset binary, 0 = two's complement |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream takes the sample |
| out_i | output | 18 | Conditioned I, left-justified |
| out_q | output | 18 | Conditioned Q, left-justified |
| sat_flag | output | 1 | Sticky saturation indicator |

## Verification
A result is due four cycles after the cycle in which its sample was accepted. During runs with out_ready held high, the bench stamps each accepted sample with its cycle number and checks that distance when the result is consumed. The sticky flag is due in the same cycle as the clamped sample's result, so it is compared with the bench's running flag at every consumed result rather than at the moment of input. Under random back-pressure, results are matched strictly in order from a queue. Inputs and outputs are sampled one step after the falling edge, so each comparison sees the values that the next rising edge will act on.

// File: rtl/iq_oc_pkg.sv
package iq_oc_pkg;
  localparam int DATA_W   = 20;
  localparam int OUT_W    = 18;
  localparam int COEF_W   = 16;
  localparam int COEF_FR  = 14;
  localparam int OFS_W    = 12;
  localparam int MIN_W    = 8;
  localparam int N_STAGES = 4;
  localparam int N_CH     = 2;
endpackage

// File: rtl/iq_oc_mac.sv
module iq_oc_mac #(
  parameter int DW   = 20,
  parameter int CW   = 16,
  parameter int FRAC = 14,
  parameter int OFW  = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [DW-1:0] x_dir,
  input  logic signed [DW-1:0] x_crs,
  input  logic signed [CW-1:0] k_dir,
  input  logic signed [CW-1:0] k_crs,
  input  logic signed [OFW-1:0] ofs,
  output logic signed [DW:0]   acc,
  output logic                 ovf
);
  localparam int PW = DW + CW;
  localparam int SW = PW + 1;
  localparam int AW = DW + 1;
  localparam logic signed [SW-1:0] BMAX = {{(SW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [SW-1:0] BMIN = ~BMAX;

  logic signed [PW-1:0] p_dir, p_crs;
  logic signed [SW-1:0] sum_w, shr_w;
  logic signed [DW-1:0] bal;
  logic                 bal_ovf;
  logic signed [AW-1:0] acc_n;

  // stage 1: products
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_dir <= '0;
      p_crs <= '0;
    end else if (en) begin
      p_dir <= x_dir * k_dir;
      p_crs <= x_crs * k_crs;
    end
  end

  // stage 2: sum, scale, clamp, offset
  always_comb begin
    sum_w   = {p_dir[PW-1], p_dir} + {p_crs[PW-1], p_crs};
    shr_w   = sum_w >>> FRAC;
    bal_ovf = 1'b0;
    if (shr_w > BMAX) begin
      bal     = {1'b0, {(DW-1){1'b1}}};
      bal_ovf = 1'b1;
    end else if (shr_w < BMIN) begin
      bal     = {1'b1, {(DW-1){1'b0}}};
      bal_ovf = 1'b1;
    end else begin
      bal = shr_w[DW-1:0];
    end
    acc_n = {bal[DW-1], bal} + {{(AW-OFW){ofs[OFW-1]}}, ofs};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      ovf <= 1'b0;
    end else if (en) begin
      acc <= acc_n;
      ovf <= bal_ovf;
    end
  end

  // R1: zero coefficients give zero products
  assert_zero_coef_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && $past(k_dir) == '0 && $past(k_crs) == '0) |-> (p_dir == '0 && p_crs == '0));
endmodule

// File: rtl/iq_oc_quant.sv
module iq_oc_quant #(
  parameter int DW = 20,
  parameter int OW = 18,
  parameter int WB = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic signed [DW:0]  acc,
  input  logic [WB-1:0]       wid,
  input  logic                sat_in,
  output logic [OW-1:0]       q_out,
  output logic                sat_out
);
  localparam int AW = DW + 1;
  localparam int RW = AW + 1;

  logic [WB-1:0]        k_w, ls_w;
  logic signed [AW-1:0] q_t;
  logic [AW-1:0]        mask, rem, half;
  logic                 up;
  logic signed [RW-1:0] qr, vmax, vmin, qc;
  logic                 clip;
  logic [OW-1:0]        q_next;

  always_comb begin
    k_w  = WB'(DW) - wid;
    ls_w = WB'(OW) - wid;
    q_t  = acc >>> k_w;
    mask = (AW'(1) << k_w) - AW'(1);
    rem  = acc & mask;
    half = AW'(1) << (k_w - WB'(1));
    up   = (rem > half) || ((rem == half) && q_t[0]);
    qr   = {q_t[AW-1], q_t} + {{AW{1'b0}}, up};
    vmax = (RW'(1) << (wid - WB'(1))) - RW'(1);
    vmin = ~vmax;
    clip = 1'b0;
    if (qr > vmax) begin
      qc   = vmax;
      clip = 1'b1;
    end else if (qr < vmin) begin
      qc   = vmin;
      clip = 1'b1;
    end else begin
      qc = qr;
    end
    q_next = OW'(qc << ls_w);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_out   <= '0;
      sat_out <= 1'b0;
    end else if (en) begin
      q_out   <= q_next;
      sat_out <= sat_in | clip;
    end
  end

  // R3: bits below the selected width are zero
  assert_low_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en) |-> ((q_out & ((OW'(1) << (WB'(OW) - $past(wid))) - OW'(1))) == '0));
endmodule

// File: rtl/iq_oc_fmt.sv
module iq_oc_fmt #(
  parameter int OW   = 18,
  parameter int NCH  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic                   offset_bin,
  input  logic [NCH-1:0][OW-1:0] din,
  output logic [NCH-1:0][OW-1:0] dout
);
  logic [OW-1:0] flip;
  assign flip = {offset_bin, {(OW-1){1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
    end else if (en) begin
      for (int ch = 0; ch < NCH; ch++) begin
        dout[ch] <= din[ch] ^ flip;
      end
    end
  end
endmodule

// File: rtl/iq_out_cond.sv
module iq_out_cond
  import iq_oc_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int OW   = OUT_W,
  parameter int CW   = COEF_W,
  parameter int FRAC = COEF_FR,
  parameter int OFW  = OFS_W,
  parameter int WMIN = MIN_W,
  localparam int WB  = $clog2(DW + 1),
  localparam int AW  = DW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_i,
  input  logic [DW-1:0] in_q,
  input  logic [CW-1:0] coef_ii,
  input  logic [CW-1:0] coef_iq,
  input  logic [CW-1:0] coef_qq,
  input  logic [CW-1:0] coef_qi,
  input  logic [OFW-1:0] ofs_i,
  input  logic [OFW-1:0] ofs_q,
  input  logic [WB-1:0] cfg_width,
  input  logic          cfg_offset_bin,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [OW-1:0] out_i,
  output logic [OW-1:0] out_q,
  output logic          sat_flag
);
  logic [N_STAGES-1:0] vld;
  logic                adv;
  logic [WB-1:0]       w_eff;

  logic [N_CH-1:0][DW-1:0]  xd, xc;
  logic [N_CH-1:0][CW-1:0]  kd, kc;
  logic [N_CH-1:0][OFW-1:0] ov;
  logic [N_CH-1:0][AW-1:0]  acc_a;
  logic [N_CH-1:0]          ovf_a, qs_a;
  logic [N_CH-1:0][OW-1:0]  q_a, f_a;

  assign adv      = !vld[N_STAGES-1] || out_ready;
  assign in_ready = adv;

  always_comb begin
    if (cfg_width < WB'(WMIN))    w_eff = WB'(WMIN);
    else if (cfg_width > WB'(OW)) w_eff = WB'(OW);
    else                          w_eff = cfg_width;
  end

  assign xd[0] = in_i;    assign xc[0] = in_q;
  assign xd[1] = in_q;    assign xc[1] = in_i;
  assign kd[0] = coef_ii; assign kc[0] = coef_iq;
  assign kd[1] = coef_qq; assign kc[1] = coef_qi;
  assign ov[0] = ofs_i;   assign ov[1] = ofs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= '0;
    else if (adv) vld <= {vld[N_STAGES-2:0], in_valid};
  end

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    iq_oc_mac #(.DW(DW), .CW(CW), .FRAC(FRAC), .OFW(OFW)) u_mac (
      .clk(clk), .rst_n(rst_n), .en(adv),
      .x_dir(xd[ch]), .x_crs(xc[ch]), .k_dir(kd[ch]), .k_crs(kc[ch]),
      .ofs(ov[ch]), .acc(acc_a[ch]), .ovf(ovf_a[ch])
    );
    iq_oc_quant #(.DW(DW), .OW(OW), .WB(WB)) u_quant (
      .clk(clk), .rst_n(rst_n), .en(adv),
      .acc(acc_a[ch]), .wid(w_eff), .sat_in(ovf_a[ch]),
      .q_out(q_a[ch]), .sat_out(qs_a[ch])
    );
  end

  iq_oc_fmt #(.OW(OW), .NCH(N_CH)) u_fmt (
    .clk(clk), .rst_n(rst_n), .en(adv), .offset_bin(cfg_offset_bin),
    .din(q_a), .dout(f_a)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sat_flag <= 1'b0;
    else if (adv && vld[N_STAGES-2] && (|qs_a)) sat_flag <= 1'b1;
  end

  assign out_valid = vld[N_STAGES-1];
  assign out_i     = f_a[0];
  assign out_q     = f_a[1];

  // R7: once raised the flag stays
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sat_flag |=> sat_flag);

  // R9: a stalled result holds its value
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_i) && $stable(out_q)));
endmodule

// File: tb/iq_out_cond_tb.sv
module iq_out_cond_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [19:0] in_i = '0, in_q = '0;
  logic        out_valid, out_ready = 1'b1;
  logic [17:0] out_i, out_q;
  logic        sat_flag;

  int ca = 16'h4000, cb = 0, cc = 16'h4000, cd = 0;
  int oi = 0, oq = 0, wv = 18;
  bit fb = 1'b0;

  iq_out_cond u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_i(in_i), .in_q(in_q),
    .coef_ii(16'(ca)), .coef_iq(16'(cb)), .coef_qq(16'(cc)), .coef_qi(16'(cd)),
    .ofs_i(12'(oi)), .ofs_q(12'(oq)), .cfg_width(5'(wv)), .cfg_offset_bin(fb),
    .out_valid(out_valid), .out_ready(out_ready), .out_i(out_i), .out_q(out_q),
    .sat_flag(sat_flag)
  );

  int checks = 0, failures = 0, cyc = 0, npush = 0, npop = 0;
  bit done = 1'b0, lat_on = 1'b0, rr_on = 1'b0, sticky = 1'b0;
  string tag = "R10";
  longint q_ei[$], q_eq[$];
  bit q_s[$], q_l[$];
  int q_c[$];
  string q_t[$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic longint chan(input longint xd, input longint xc, input longint kd,
                                  input longint kc, input longint of, input int w,
                                  input bit f, output bit s);
    longint p, a, q, r, h, mx, res;
    int we, k;
    we = (w < 8) ? 8 : ((w > 18) ? 18 : w);
    k  = 20 - we;
    s  = 1'b0;
    p  = (xd * kd + xc * kc) >>> 14;
    if (p > 524287)  begin p = 524287;  s = 1'b1; end
    if (p < -524288) begin p = -524288; s = 1'b1; end
    a = p + of;
    q = a >>> k;
    r = a - (q <<< k);
    h = longint'(1) << (k - 1);
    if (r > h || (r == h && (q & 1) != 0)) q = q + 1;
    mx = (longint'(1) << (we - 1)) - 1;
    if (q > mx)      begin q = mx;      s = 1'b1; end
    if (q < -mx - 1) begin q = -mx - 1; s = 1'b1; end
    res = (q << (18 - we)) & 'h3FFFF;
    if (f) res = res ^ 'h20000;
    return res;
  endfunction

  task automatic pop_check();
    longint ei, eq;
    bit s, l;
    int c;
    string t;
    ei = q_ei.pop_front(); eq = q_eq.pop_front();
    s = q_s.pop_front(); l = q_l.pop_front(); c = q_c.pop_front(); t = q_t.pop_front();
    npop++;
    chk(longint'(out_i) == ei, {t, " out_i"}, longint'(out_i), ei);
    chk(longint'(out_q) == eq, {t, " out_q"}, longint'(out_q), eq);
    sticky = sticky | s;
    chk(sat_flag == sticky, "R7 sat_flag", longint'(sat_flag), longint'(sticky));
    if (l) chk(cyc - c == 4, "R8 latency", longint'(cyc - c), 4);
  endtask

  task automatic tick(input bit v, input int xi, input int xq, output bit took);
    bit si, sq;
    longint ei, eq;
    @(negedge clk);
    cyc++;
    out_ready = rr_on ? 1'($urandom_range(0, 1)) : 1'b1;
    in_valid  = v;
    in_i      = 20'(xi);
    in_q      = 20'(xq);
    #1;
    if (out_valid && out_ready) pop_check();
    took = v && in_ready;
    if (took) begin
      ei = chan(xi, xq, ca, cb, oi, wv, fb, si);
      eq = chan(xq, xi, cc, cd, oq, wv, fb, sq);
      q_ei.push_back(ei); q_eq.push_back(eq); q_s.push_back(si | sq);
      q_l.push_back(lat_on); q_c.push_back(cyc); q_t.push_back(tag);
      npush++;
    end
  endtask

  task automatic send(input int xi, input int xq);
    bit t;
    do tick(1'b1, xi, xq, t); while (!t);
  endtask

  task automatic idle(input int n);
    bit t;
    for (int j = 0; j < n; j++) tick(1'b0, 0, 0, t);
  endtask

  task automatic drain();
    bit t;
    int guard = 0;
    rr_on = 1'b0;
    while (q_ei.size() != 0 && guard < 1000) begin
      tick(1'b0, 0, 0, t);
      guard++;
    end
    idle(2);
  endtask

  function automatic int rnd(input int lim);
    return int'($urandom_range(0, 2 * lim)) - lim;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit t;
    repeat (3) @(negedge clk);
    #1;
    // R10: state held in reset
    chk(out_valid == 1'b0, "R10 out_valid", longint'(out_valid), 0);
    chk(sat_flag == 1'b0, "R10 sat_flag", longint'(sat_flag), 0);
    chk(out_i == '0 && out_q == '0, "R10 out data", longint'(out_i), 0);
    rst_n = 1'b1;
    idle(2);
    chk(in_ready == 1'b1, "R10 in_ready", longint'(in_ready), 1);
    chk(out_valid == 1'b0, "R10 out_valid after release", longint'(out_valid), 0);

    // R8: unity pass-through with latency stamps
    tag = "R8"; lat_on = 1'b1;
    send(0, 0); send(1000, -1000); send(-1000, 1000); send(100000, -100000);
    idle(1); send(12345, 54321);
    drain(); lat_on = 1'b0;

    // R1: balance matrix
    tag = "R1"; ca = 16'h3000; cb = 16'h0800; cc = 16'h4400; cd = -1024;
    for (int j = 0; j < 20; j++) send(rnd(300000), rnd(300000));
    send(-7, 3); send(7, -3);
    drain();

    // R2: quarter-LSB offsets
    tag = "R2"; ca = 16'h4000; cb = 0; cc = 16'h4000; cd = 0; oi = 5; oq = -7;
    send(0, 0); send(1, -1); send(-3, 2); send(400, -400);
    drain(); wv = 12; oi = 2047; oq = -2048;
    for (int j = 0; j < 10; j++) send(rnd(200000), rnd(200000));
    drain(); oi = 0; oq = 0;

    // R4: ties to even
    tag = "R4"; wv = 16;
    send(24, 40); send(-24, -40); send(23, 25); send(8, -8); send(56, -56);
    drain(); wv = 8;
    send(2048, 6144); send(-2048, -6144); send(2049, -2049);
    drain();

    // R3: width clamp and sweep
    tag = "R3"; wv = 3;
    for (int j = 0; j < 6; j++) send(rnd(300000), rnd(300000));
    drain(); wv = 25;
    for (int j = 0; j < 6; j++) send(rnd(300000), rnd(300000));
    drain();
    for (int w = 8; w <= 18; w++) begin
      wv = w;
      send(rnd(300000), rnd(300000)); send(rnd(300000), rnd(300000));
      drain();
    end

    // R5: offset binary
    tag = "R5"; wv = 10; fb = 1'b1;
    send(0, 0); send(-200000, 200000);
    for (int j = 0; j < 8; j++) send(rnd(300000), rnd(300000));
    drain(); fb = 1'b0;

    // R6: saturation at the width and in the balance sum
    tag = "R6"; wv = 8;
    send(524000, -524000); send(100, 100);
    drain();
    ca = 16'h7FFF; cb = 16'h7FFF; cc = 16'h7FFF; cd = 16'h7FFF; wv = 18;
    send(500000, 500000); send(-500000, -500000);
    drain();

    // R9: random back-pressure and gaps
    tag = "R9"; ca = 16'h3C00; cb = 300; cc = 16'h4200; cd = -300; oi = 9; oq = -3; wv = 14;
    for (int j = 0; j < 300; j++) begin
      rr_on = 1'b1;
      if ($urandom_range(0, 2) != 0) send(rnd(300000), rnd(300000));
      else tick(1'b0, 0, 0, t);
    end
    drain();
    chk(npush == npop, "R9 nothing lost", longint'(npop), longint'(npush));
    chk(out_valid == 1'b0, "R9 pipe empty", longint'(out_valid), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule